// File: doc/BRIEF.md
# Framed Receive FIFO with Per-Word Flags

This block sits behind the byte-level receiver of a framed serial link, such as an infrared port. It packs incoming bytes into 32-bit words, little-endian. It stores each word in an 8-entry FIFO together with a 7-bit flag field, and it marks the word that closes each frame. A DMA engine or an interrupt handler drains the FIFO through a pop strobe. The head entry is always visible on the read ports. A service request is raised whenever the FIFO holds data, including a final word that carries only 1 to 3 bytes, so no processor action is needed between frames.

Error handling follows frame boundaries. After an overrun or a framing error, the remaining bytes of the frame are dropped until the next end-of-frame or abort, and no service request is made while that discard is in progress. An overrun marks the newest stored entry. If that entry already closes an earlier frame, a frame-lost pulse is raised instead. A framing error appends a dedicated entry whose data field is zero. Errors seen in the current frame are also held in a sticky status word. A loopback control routes the transmit shifter's bytes into the receive path. Dropping the receive enable flushes everything.

Top module: `frm_rx_fifo`

## Requirements
- R1: Bytes are packed little-endian, with the first byte of a word in bits 7:0. A word that has 4 bytes is written to the FIFO when the next byte arrives, or when the frame ends.
- R2: Entry flag field (rd_flags_o): bit0 end-of-frame, bit1 overrun, bit2 framing error, bit3 abort, bit4 CRC error, bits 6:5 valid-byte count (0 means 4 bytes, 1 to 3 mean that many bytes).
- R3: frame_end_i or frame_abort_i with 1 to 4 bytes pending writes the last word with end-of-frame set. Abort sets bit3 as well. frame_end_i with crc_bad_i sets bit4. With no bytes pending, nothing is written.
- R4: rd_valid_o is high while the FIFO is not empty. A pop (rd_i while valid) removes the head entry, and the next entry appears on the following cycle.
- R5: A write into a full FIFO is an overrun. If the newest entry has end-of-frame clear, that entry gets bits 1 and 0 set. The rest of the frame is then discarded until frame_end_i or frame_abort_i.
- R6: If the newest entry already has end-of-frame set when an overrun occurs, frame_lost_o pulses for one cycle and the FIFO contents are not changed.
- R7: frame_err_i outside discard drops any pending bytes and appends one entry with flags 0x05 and data zero. Discard then lasts until the frame ends. A further frame_err_i during discard has no effect.
- R8: req_o is high when the FIFO is not empty and no discard is in progress, and low otherwise.
- R9: err_o holds sticky frame errors: bit0 overrun, bit1 framing, bit2 abort, bit3 CRC. It is cleared when the first byte of the next frame is accepted.
- R10: While rx_en_i is low, the FIFO, the packer, the discard state and err_o are cleared, and all inputs are ignored.
- R11: With loopback_i high, bytes are taken from tx_byte_i/tx_byte_vld_i and the rx_byte inputs are ignored.
- R12: The FIFO fill level never exceeds its depth of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low flushes the block |
| loopback_i | input | 1 | Take bytes from the transmit shifter |
| rx_byte_i | input | 8 | Byte from the receive shifter |
| rx_byte_vld_i | input | 1 | rx_byte_i is valid this cycle |
| tx_byte_i | input | 8 | Byte from the transmit shifter (loopback) |
| tx_byte_vld_i | input | 1 | tx_byte_i is valid this cycle |
| frame_end_i | input | 1 | Valid end of frame |
| crc_bad_i | input | 1 | CRC failed; qualified by frame_end_i |
| frame_abort_i | input | 1 | Frame aborted |
| frame_err_i | input | 1 | Framing error detected |
| rd_i | input | 1 | Pop head entry |
| rd_data_o | output | 32 | Head entry data |
| rd_flags_o | output | 7 | Head entry flags |
| rd_valid_o | output | 1 | FIFO not empty |
| req_o | output | 1 | Service request |
| frame_lost_o | output | 1 | Overrun after a completed frame; one-cycle pulse |
| err_o | output | 4 | Sticky errors of the current frame |

## Verification
The bench fills the FIFO to exactly eight words and then forces a ninth write, once in the middle of a frame and once at a frame boundary. A design that tagged the wrong slot, or that ignored the end-of-frame bit already on the newest entry, would corrupt a completed frame or miss the frame-lost pulse. It checks that req_o stays low while bytes are being discarded after an error, and that the framing-error entry carries zero data with no stale bytes from the packer. A design that kept stale bytes or requested early would hand half frames to DMA. Random traffic with pops in the same cycle, loopback switching and short disable pulses is compared against a reference model, which catches sticky errors that clear at the wrong time and partial words given the wrong byte count.

// File: rtl/frm_rx_pkg.sv
`timescale 1ns/1ps
package frm_rx_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned WORD_W = 8 * LANES;
  localparam int unsigned FLAG_W = 7;
  localparam int unsigned ENTRY_W = WORD_W + FLAG_W;
  localparam int unsigned CNT_W = $clog2(LANES + 1);
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned ERR_W = 4;
  // sticky error bit positions
  localparam int unsigned E_OVR = 0;
  localparam int unsigned E_FE  = 1;
  localparam int unsigned E_AB  = 2;
  localparam int unsigned E_CRC = 3;

  typedef struct packed {
    logic [LANE_W-1:0] nbytes;
    logic              crc;
    logic              abort;
    logic              fe;
    logic              ovr;
    logic              eof;
    logic [WORD_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/frm_rx_packer.sv
`timescale 1ns/1ps
module frm_rx_packer
  import frm_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [WORD_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LANE_W-1:0] lane;

  assign lane = cnt_q[LANE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (byte_vld_i) begin
      if (cnt_q == CNT_W'(LANES)) begin
        data_q      <= '0;
        data_q[7:0] <= byte_i;
        cnt_q       <= CNT_W'(1);
      end else begin
        data_q[8*lane +: 8] <= byte_i;
        cnt_q               <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign word_o = data_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/frm_rx_store.sv
`timescale 1ns/1ps
module frm_rx_store
  import frm_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = PW + 1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    flush_i,
  input  logic    push_i,
  input  entry_t  push_data_i,
  input  logic    pop_i,
  input  logic    tag_i,
  output entry_t  head_o,
  output logic    newest_eof_o,
  output logic [LW-1:0] fill_o
);
  entry_t          mem_q [DEPTH];
  logic [PW-1:0]   wr_q, rd_q, newest;
  logic [LW-1:0]   fill_q;

  assign newest = wr_q - PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else if (flush_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + PW'(1);
      if (pop_i)  rd_q <= rd_q + PW'(1);
      if (push_i && !pop_i)      fill_q <= fill_q + LW'(1);
      else if (pop_i && !push_i) fill_q <= fill_q - LW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      if (push_i) mem_q[wr_q] <= push_data_i;
      else if (tag_i) begin
        mem_q[newest].ovr <= 1'b1;
        mem_q[newest].eof <= 1'b1;
      end
    end
  end

  assign head_o       = mem_q[rd_q];
  assign newest_eof_o = mem_q[newest].eof;
  assign fill_o       = fill_q;
endmodule

// File: rtl/frm_rx_fifo.sv
`timescale 1ns/1ps
module frm_rx_fifo
  import frm_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              loopback_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              rx_byte_vld_i,
  input  logic [7:0]        tx_byte_i,
  input  logic              tx_byte_vld_i,
  input  logic              frame_end_i,
  input  logic              crc_bad_i,
  input  logic              frame_abort_i,
  input  logic              frame_err_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [FLAG_W-1:0] rd_flags_o,
  output logic              rd_valid_o,
  output logic              req_o,
  output logic              frame_lost_o,
  output logic [ERR_W-1:0]  err_o
);
  localparam int unsigned LW = $clog2(DEPTH) + 1;

  logic              src_vld;
  logic [7:0]        src_byte;
  logic [WORD_W-1:0] pk_word;
  logic [CNT_W-1:0]  pk_cnt;
  logic              pk_clr, pk_vld;
  logic [LW-1:0]     fill;
  logic              full, empty, newest_eof;
  entry_t            head, entry;
  logic              push, pop, ovr_hit, tag, lost;
  logic              discard_q, discard_d, open_q, open_d, lost_q;
  logic [ERR_W-1:0]  sticky_q, sticky_d;

  assign src_vld  = loopback_i ? tx_byte_vld_i : rx_byte_vld_i;
  assign src_byte = loopback_i ? tx_byte_i : rx_byte_i;
  assign full     = (fill == LW'(DEPTH));
  assign empty    = (fill == '0);
  assign pop      = rx_en_i && rd_i && !empty;

  always_comb begin
    push      = 1'b0;
    entry     = '0;
    ovr_hit   = 1'b0;
    pk_clr    = !rx_en_i;
    pk_vld    = 1'b0;
    discard_d = discard_q;
    open_d    = open_q;
    sticky_d  = sticky_q;
    if (rx_en_i) begin
      if (frame_err_i) begin
        if (!discard_q) begin
          sticky_d[E_FE] = 1'b1;
          pk_clr    = 1'b1;
          discard_d = 1'b1;
          open_d    = 1'b1;
          if (full) ovr_hit = 1'b1;
          else begin
            push      = 1'b1;
            entry.fe  = 1'b1;
            entry.eof = 1'b1;
          end
        end
      end else if (frame_end_i || frame_abort_i) begin
        if (frame_abort_i) sticky_d[E_AB] = 1'b1;
        else if (crc_bad_i) sticky_d[E_CRC] = 1'b1;
        if (!discard_q && pk_cnt != '0) begin
          if (full) ovr_hit = 1'b1;
          else begin
            push         = 1'b1;
            entry.data   = pk_word;
            entry.nbytes = pk_cnt[LANE_W-1:0];
            entry.abort  = frame_abort_i;
            entry.crc    = !frame_abort_i && crc_bad_i;
            entry.eof    = 1'b1;
          end
        end
        pk_clr    = 1'b1;
        discard_d = 1'b0;
        open_d    = 1'b0;
      end else if (src_vld && !discard_q) begin
        if (!open_q) begin
          sticky_d = '0;
          open_d   = 1'b1;
        end
        if (pk_cnt == CNT_W'(LANES)) begin
          if (full) begin
            ovr_hit   = 1'b1;
            discard_d = 1'b1;
            pk_clr    = 1'b1;
          end else begin
            push       = 1'b1;
            entry.data = pk_word;
            pk_vld     = 1'b1;
          end
        end else pk_vld = 1'b1;
      end
      if (ovr_hit) sticky_d[E_OVR] = 1'b1;
    end
  end

  assign tag  = ovr_hit && !newest_eof;
  assign lost = ovr_hit && newest_eof;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      discard_q <= 1'b0;
      open_q    <= 1'b0;
      sticky_q  <= '0;
      lost_q    <= 1'b0;
    end else if (!rx_en_i) begin
      discard_q <= 1'b0;
      open_q    <= 1'b0;
      sticky_q  <= '0;
      lost_q    <= 1'b0;
    end else begin
      discard_q <= discard_d;
      open_q    <= open_d;
      sticky_q  <= sticky_d;
      lost_q    <= lost;
    end
  end

  frm_rx_packer u_packer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (pk_clr),
    .byte_vld_i (pk_vld),
    .byte_i     (src_byte),
    .word_o     (pk_word),
    .cnt_o      (pk_cnt)
  );

  frm_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (!rx_en_i),
    .push_i       (push),
    .push_data_i  (entry),
    .pop_i        (pop),
    .tag_i        (tag),
    .head_o       (head),
    .newest_eof_o (newest_eof),
    .fill_o       (fill)
  );

  assign rd_data_o    = head.data;
  assign rd_flags_o   = head[ENTRY_W-1:WORD_W];
  assign rd_valid_o   = !empty;
  assign req_o        = !empty && !discard_q;
  assign frame_lost_o = lost_q;
  assign err_o        = sticky_q;
endmodule

// File: rtl/frm_rx_fifo_chk.sv
`timescale 1ns/1ps
module frm_rx_fifo_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic          frame_err_i,
  input logic          req_o,
  input logic          rd_valid_o,
  input logic [6:0]    rd_flags_o,
  input logic [31:0]   rd_data_o,
  input logic          frame_lost_o,
  input logic [LW-1:0] fill_i
);
  assert_no_overflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= LW'(DEPTH));

  assert_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rd_valid_o);

  assert_discard_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i && frame_err_i |=> !req_o);

  assert_fe_entry_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_flags_o[2] |-> rd_data_o == 32'h0);

  assert_lost_when_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_lost_o |-> fill_i >= LW'(DEPTH - 1));
endmodule

bind frm_rx_fifo frm_rx_fifo_chk #(.DEPTH(DEPTH), .LW($clog2(DEPTH) + 1)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_en_i      (rx_en_i),
  .frame_err_i  (frame_err_i),
  .req_o        (req_o),
  .rd_valid_o   (rd_valid_o),
  .rd_flags_o   (rd_flags_o),
  .rd_data_o    (rd_data_o),
  .frame_lost_o (frame_lost_o),
  .fill_i       (fill)
);

// File: tb/frm_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module frm_rx_fifo_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_en_i = 1'b0, loopback_i = 1'b0;
  logic [7:0]  rx_byte_i = '0, tx_byte_i = '0;
  logic        rx_byte_vld_i = 1'b0, tx_byte_vld_i = 1'b0;
  logic        frame_end_i = 1'b0, crc_bad_i = 1'b0, frame_abort_i = 1'b0;
  logic        frame_err_i = 1'b0, rd_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [6:0]  rd_flags_o;
  logic        rd_valid_o, req_o, frame_lost_o;
  logic [3:0]  err_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  logic [38:0] mq[$];
  logic [31:0] m_acc;
  int          m_cnt;
  bit          m_disc, m_open, m_lost;
  logic [3:0]  m_err;

  always #2.5 clk_i = ~clk_i;

  frm_rx_fifo dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    mq.delete(); m_acc = '0; m_cnt = 0; m_disc = 0; m_open = 0; m_err = '0; m_lost = 0;
  endtask

  task automatic m_overrun();
    m_err[0] = 1'b1;
    if (mq[mq.size()-1][32] == 1'b0) mq[mq.size()-1][33:32] = 2'b11;
    else m_lost = 1;
  endtask

  task automatic m_step(input bit en, lb, bv, input logic [7:0] b, input bit tv,
                        input logic [7:0] tb, input bit eof, crc, ab, fe, rd);
    bit full, sv, pop;
    logic [7:0] sb;
    m_lost = 0;
    if (!en) begin m_reset(); return; end
    full = (mq.size() == 8);
    pop  = rd && mq.size() > 0;
    sv   = lb ? tv : bv;
    sb   = lb ? tb : b;
    if (pop) void'(mq.pop_front());
    if (fe) begin
      if (!m_disc) begin
        m_err[1] = 1; m_acc = '0; m_cnt = 0; m_disc = 1; m_open = 1;
        if (full) m_overrun(); else mq.push_back({7'h05, 32'h0});
      end
    end else if (eof || ab) begin
      if (ab) m_err[2] = 1; else if (crc) m_err[3] = 1;
      if (!m_disc && m_cnt > 0) begin
        if (full) m_overrun();
        else mq.push_back({m_cnt[1:0], (!ab && crc), ab, 1'b0, 1'b0, 1'b1, m_acc});
      end
      m_acc = '0; m_cnt = 0; m_disc = 0; m_open = 0;
    end else if (sv && !m_disc) begin
      if (!m_open) begin m_err = '0; m_open = 1; end
      if (m_cnt == 4) begin
        if (full) begin m_overrun(); m_disc = 1; m_acc = '0; m_cnt = 0; end
        else begin mq.push_back({7'h00, m_acc}); m_acc = {24'h0, sb}; m_cnt = 1; end
      end else begin
        m_acc[8*m_cnt +: 8] = sb; m_cnt++;
      end
    end
  endtask

  task automatic cyc(input bit en, lb, bv, input logic [7:0] b, input bit tv,
                     input logic [7:0] tb, input bit eof, crc, ab, fe, rd);
    rx_en_i = en; loopback_i = lb; rx_byte_vld_i = bv; rx_byte_i = b;
    tx_byte_vld_i = tv; tx_byte_i = tb; frame_end_i = eof; crc_bad_i = crc;
    frame_abort_i = ab; frame_err_i = fe; rd_i = rd;
    @(posedge clk_i);
    m_step(en, lb, bv, b, tv, tb, eof, crc, ab, fe, rd);
    @(negedge clk_i);
    check(rd_valid_o == (mq.size() > 0), "R4 valid", 64'(rd_valid_o), 64'(mq.size() > 0));
    if (rd_valid_o && mq.size() > 0)
      check({rd_flags_o, rd_data_o} == mq[0], "R4 head", {25'h0, rd_flags_o, rd_data_o}, {25'h0, mq[0]});
    check(req_o == (mq.size() > 0 && !m_disc), "R8 req", 64'(req_o), 64'(mq.size() > 0 && !m_disc));
    check(err_o == m_err, "R9 sticky", 64'(err_o), 64'(m_err));
    check(frame_lost_o == m_lost, "R6 lost", 64'(frame_lost_o), 64'(m_lost));
  endtask

  task automatic sbyte(input logic [7:0] b); cyc(1,0,1,b,0,0,0,0,0,0,0); endtask
  task automatic fend(input bit crc);        cyc(1,0,0,0,0,0,1,crc,0,0,0); endtask
  task automatic fabort();                   cyc(1,0,0,0,0,0,0,0,1,0,0); endtask
  task automatic ferr();                     cyc(1,0,0,0,0,0,0,0,0,1,0); endtask
  task automatic pop1();                     cyc(1,0,0,0,0,0,0,0,0,0,1); endtask
  task automatic flush();                    cyc(0,0,0,0,0,0,0,0,0,0,0); endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!rd_valid_o && !req_o && err_o == 0 && !frame_lost_o, "R10 reset", 64'(rd_valid_o), 0);

    // R1 R2: five bytes then end of frame
    for (int i = 1; i <= 5; i++) sbyte(8'(i * 17));
    fend(1);
    check(rd_data_o == 32'h44332211 && rd_flags_o == 7'h00, "R1 first word", 64'(rd_data_o), 64'h44332211);
    pop1();
    check(rd_data_o == 32'h55 && rd_flags_o == 7'h31, "R2 partial word flags", 64'(rd_flags_o), 64'h31);
    check(err_o == 4'b1000, "R9 crc sticky", 64'(err_o), 64'h8);
    pop1();

    // R3: abort after two bytes
    sbyte(8'hA1); sbyte(8'hB2);
    check(err_o == 4'b0000, "R9 cleared on new frame", 64'(err_o), 0);
    fabort();
    check(rd_data_o == 32'hB2A1 && rd_flags_o == 7'h49, "R3 abort word", 64'(rd_flags_o), 64'h49);
    pop1();

    // R7: framing error drops pending bytes, appends error entry, discards
    sbyte(8'h01); sbyte(8'h02); ferr();
    check(rd_flags_o == 7'h05 && rd_data_o == 0, "R7 error entry", 64'(rd_flags_o), 64'h05);
    check(!req_o, "R8 no req while discarding", 64'(req_o), 0);
    ferr(); sbyte(8'h03);
    fend(0);
    check(req_o, "R8 req after discard ends", 64'(req_o), 1);
    pop1();
    check(!rd_valid_o, "R7 single entry", 64'(rd_valid_o), 0);

    // R5: overrun mid-frame
    flush();
    for (int i = 1; i <= 37; i++) sbyte(8'(i));
    sbyte(8'hEE); sbyte(8'hEF);
    check(!req_o, "R5 discard after overrun", 64'(req_o), 0);
    fend(0);
    for (int i = 0; i < 7; i++) pop1();
    check(rd_flags_o == 7'h03 && rd_data_o == 32'h201F1E1D, "R5 tagged newest", 64'(rd_flags_o), 64'h03);
    pop1();

    // R6: overrun after completed frames
    flush();
    for (int i = 0; i < 8; i++) begin sbyte(8'(i)); fend(0); end
    sbyte(8'h99); fend(0);
    check(frame_lost_o == 1'b1, "R6 lost pulse", 64'(frame_lost_o), 1);
    cyc(1,0,0,0,0,0,0,0,0,0,0);
    check(frame_lost_o == 1'b0, "R6 pulse one cycle", 64'(frame_lost_o), 0);
    check(rd_flags_o == 7'h21 && rd_data_o == 0, "R6 head untouched", 64'(rd_flags_o), 64'h21);
    for (int i = 0; i < 8; i++) pop1();

    // R11: loopback
    for (int i = 0; i < 3; i++) cyc(1,1,1,8'hFF,1,8'(8'h40 + i),0,0,0,0,0);
    cyc(1,1,0,0,0,0,1,0,0,0,0);
    check(rd_data_o == 32'h424140 && rd_flags_o == 7'h61, "R11 loopback source", 64'(rd_data_o), 64'h424140);
    cyc(1,0,0,0,1,8'h77,0,0,0,0,0);

    // R10: flush
    flush();
    check(!rd_valid_o && err_o == 0, "R10 flush", 64'(rd_valid_o), 0);

    // random traffic
    void'($urandom(32'd20240517));
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit en, lb, bv, tv, eof, ab, fe, rd, crc;
      r   = $urandom_range(0, 99);
      en  = ($urandom_range(0, 399) != 0);
      lb  = ($urandom_range(0, 9) == 0);
      bv  = (r < 58); tv = (r < 58);
      eof = (r >= 58 && r < 65);
      ab  = (r >= 65 && r < 67);
      fe  = (r >= 67 && r < 69);
      crc = $urandom_range(0, 1) == 1;
      rd  = ($urandom_range(0, 99) < 40);
      cyc(en, lb, bv, 8'($urandom_range(0, 255)), tv, 8'($urandom_range(0, 255)), eof, crc, ab, fe, rd);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule